// File: doc/BRIEF.md
# Byte-Addressed Three-Phase Register Processor

This block is a very small stored-program processor. Its program and data share one 256-byte memory. Each instruction is 16 bits wide and takes two adjacent bytes. The byte at the lower address supplies the upper eight bits of the instruction. The top nibble selects the operation, and the other three nibbles carry register numbers or an 8-bit address.

Every instruction passes through three clock cycles in a fixed order:

- **Fetch:** the two bytes at the program counter are copied into the instruction register, and the program counter moves forward by two.
- **Decode:** the operands are captured from the register file or from memory.
- **Execute:** the result is written, the branch is resolved, or the core halts.

The machine has sixteen 8-bit general registers. It supports five operations: byte load, byte store, two's-complement addition, a compare-with-register-zero jump, and halt.

A test environment uses the core in three steps. While the core is held in reset, the environment writes the memory image through a loader port and presents the start address. It then releases reset and waits for the halted flag. Finally, it inspects registers and memory through two combinational debug read ports.

Top module: `tcpu_core`

## Requirements
- R1: While reset is applied and right after it is released, halted is 0 and all sixteen registers read 0. The first instruction fetched is the one at `start_addr`, sampled when reset is released.
- R2: The instruction word is {mem[pc], mem[pc+1]}, so the lower address holds bits 15:8. After each fetch the program counter advances by 2, modulo 256. An instruction that starts at 0xFF takes its low byte from 0x00.
- R3: Opcode 0x1, word 1RXY, copies the memory byte at address XY (bits 7:0) into register R (bits 11:8).
- R4: Opcode 0x3, word 3RXY, writes register R into the memory byte at address XY.
- R5: Opcode 0x5, word 5RST, writes (reg S + reg T) mod 256 into register R. S is bits 7:4 and T is bits 3:0. Signed overflow wraps silently, for example 0x7F + 0x01 gives 0x80.
- R6: Opcode 0xB, word BRXY, loads XY into the program counter when register R equals register 0. When R is 0, the jump is always taken. Otherwise execution continues with the next instruction.
- R7: Opcode 0xC sets halted. After that, halted stays 1, no further instruction is fetched, and registers and memory stay unchanged until the next reset.
- R8: Opcodes 0x0, 0x2, 0x4, 0x6 to 0xA and 0xD to 0xF change no register and no memory byte, and execution continues with the next instruction.
- R9: Every instruction takes exactly three cycles. Placing k extra non-halting instructions before a halt therefore delays the rise of halted by exactly 3k cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| start_addr | input | 8 | Address of the first instruction |
| ld_we | input | 1 | Loader write strobe; it takes priority over core stores |
| ld_addr | input | 8 | Loader write address |
| ld_data | input | 8 | Loader write data |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_reg_idx | input | 4 | Register select for the debug read port |
| dbg_reg_val | output | 8 | Value of the selected register |
| dbg_mem_addr | input | 8 | Address for the debug memory read port |
| dbg_mem_val | output | 8 | Memory byte at dbg_mem_addr |

## Verification
The bench uses the default parameters: 8-bit bytes and addresses, sixteen registers and a full 256-byte memory. With these values every address an instruction can name actually exists. This brings program-counter wrap from 0xFF to 0x00, and an instruction that straddles that boundary, within reach of directed programs. Random programs run stores, loads, additions and forward jumps against a 64-byte data window, and they mix in undefined opcodes. Each result is compared byte for byte with an instruction-level model in the bench.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;
  localparam int BYTE_W  = 8;
  localparam int INSTR_W = 2 * BYTE_W;
  localparam int ADDR_W  = BYTE_W;
  localparam int OPC_W   = 4;
  localparam int RIDX_W  = 4;
  localparam int NREG    = 1 << RIDX_W;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h3;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 4'hB;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'hC;

  typedef enum logic [2:0] {
    PH_BOOT   = 3'd0,
    PH_FETCH  = 3'd1,
    PH_DECODE = 3'd2,
    PH_EXEC   = 3'd3,
    PH_HALT   = 3'd4
  } phase_e;

  typedef struct packed {
    logic wr_reg;
    logic sel_sum;
    logic wr_mem;
    logic branch;
    logic halt;
  } ctrl_t;

  function automatic ctrl_t decode_op(logic [OPC_W-1:0] opc);
    ctrl_t c;
    c = '0;
    case (opc)
      OPC_LOAD:  c.wr_reg = 1'b1;
      OPC_STORE: c.wr_mem = 1'b1;
      OPC_ADD:   begin c.wr_reg = 1'b1; c.sel_sum = 1'b1; end
      OPC_JUMP:  c.branch = 1'b1;
      OPC_HALT:  c.halt   = 1'b1;
      default:   c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tcpu_mem.sv
module tcpu_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] ra0,
  output logic [DATA_W-1:0] rd0,
  input  logic [ADDR_W-1:0] ra1,
  output logic [DATA_W-1:0] rd1,
  input  logic [ADDR_W-1:0] ra2,
  output logic [DATA_W-1:0] rd2,
  input  logic [ADDR_W-1:0] ra3,
  output logic [DATA_W-1:0] rd3
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store_q [DEPTH];

  // Storage array has no reset; contents come from the loader.
  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rd0 = store_q[ra0];
  assign rd1 = store_q[ra1];
  assign rd2 = store_q[ra2];
  assign rd3 = store_q[ra3];
endmodule

// File: rtl/tcpu_regfile.sv
module tcpu_regfile #(
  parameter int DATA_W = 8,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RIDX_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RIDX_W-1:0] ridx_a,
  output logic [DATA_W-1:0] rval_a,
  input  logic [RIDX_W-1:0] ridx_b,
  output logic [DATA_W-1:0] rval_b,
  input  logic [RIDX_W-1:0] ridx_d,
  output logic [DATA_W-1:0] rval_d
);
  localparam int NREG = 1 << RIDX_W;

  logic [DATA_W-1:0] regs_q [NREG];
  logic [NREG-1:0]   wen;

  for (genvar g = 0; g < NREG; g++) begin : g_wen
    assign wen[g] = we && (widx == RIDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wen[i]) regs_q[i] <= wdata;
      end
    end
  end

  assign rval_a = regs_q[ridx_a];
  assign rval_b = regs_q[ridx_b];
  assign rval_d = regs_q[ridx_d];
endmodule

// File: rtl/tcpu_seq.sv
module tcpu_seq
  import tcpu_pkg::*;
#(
  parameter int DATA_W  = BYTE_W,
  parameter int ADDR_W  = BYTE_W,
  parameter int RIDX_W  = 4,
  parameter int INSTR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] fetch_addr_hi,
  output logic [ADDR_W-1:0] fetch_addr_lo,
  input  logic [DATA_W-1:0] fetch_hi,
  input  logic [DATA_W-1:0] fetch_lo,
  output logic [ADDR_W-1:0] opnd_addr,
  input  logic [DATA_W-1:0] opnd_byte,
  output logic [RIDX_W-1:0] rd_idx_a,
  output logic [RIDX_W-1:0] rd_idx_b,
  input  logic [DATA_W-1:0] rd_val_a,
  input  logic [DATA_W-1:0] rd_val_b,
  output logic              reg_we,
  output logic [RIDX_W-1:0] reg_widx,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pc,
  output phase_e            phase
);
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int R_LSB   = OPC_LSB - RIDX_W;
  localparam int S_LSB   = R_LSB - RIDX_W;

  phase_e             phase_q, phase_d;
  logic [ADDR_W-1:0]  pc_q, pc_d;
  logic               pc_en, ir_en, opnd_en;
  logic [INSTR_W-1:0] ir_q;
  logic [DATA_W-1:0]  opa_q, opb_q, ldb_q;
  ctrl_t              ctrl_q;

  logic [OPC_W-1:0]   f_opc;
  logic [RIDX_W-1:0]  f_r, f_s, f_t;
  logic [ADDR_W-1:0]  f_xy;

  assign f_opc = ir_q[INSTR_W-1:OPC_LSB];
  assign f_r   = ir_q[OPC_LSB-1:R_LSB];
  assign f_s   = ir_q[R_LSB-1:S_LSB];
  assign f_t   = ir_q[S_LSB-1:0];
  assign f_xy  = ir_q[ADDR_W-1:0];

  // Operand routing: adds read S and T, jumps compare R with register 0.
  assign rd_idx_a      = (f_opc == OPC_ADD) ? f_s : f_r;
  assign rd_idx_b      = (f_opc == OPC_ADD) ? f_t : '0;
  assign opnd_addr     = f_xy;
  assign fetch_addr_hi = pc_q;
  assign fetch_addr_lo = pc_q + ADDR_W'(1);

  assign reg_widx  = f_r;
  assign reg_wdata = ctrl_q.sel_sum ? (opa_q + opb_q) : ldb_q;
  assign mem_waddr = f_xy;
  assign mem_wdata = opa_q;

  always_comb begin
    phase_d = phase_q;
    pc_d    = pc_q;
    pc_en   = 1'b0;
    ir_en   = 1'b0;
    opnd_en = 1'b0;
    reg_we  = 1'b0;
    mem_we  = 1'b0;
    case (phase_q)
      PH_BOOT: begin
        pc_d    = start_addr;
        pc_en   = 1'b1;
        phase_d = PH_FETCH;
      end
      PH_FETCH: begin
        ir_en   = 1'b1;
        pc_d    = pc_q + ADDR_W'(2);
        pc_en   = 1'b1;
        phase_d = PH_DECODE;
      end
      PH_DECODE: begin
        opnd_en = 1'b1;
        phase_d = PH_EXEC;
      end
      PH_EXEC: begin
        reg_we = ctrl_q.wr_reg;
        mem_we = ctrl_q.wr_mem;
        if (ctrl_q.branch && (opa_q == opb_q)) begin
          pc_d  = f_xy;
          pc_en = 1'b1;
        end
        phase_d = ctrl_q.halt ? PH_HALT : PH_FETCH;
      end
      PH_HALT: phase_d = PH_HALT;
      default: phase_d = PH_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_BOOT;
      pc_q    <= '0;
      ir_q    <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      ldb_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (pc_en) pc_q <= pc_d;
      if (ir_en) ir_q <= {fetch_hi, fetch_lo};
      if (opnd_en) begin
        opa_q  <= rd_val_a;
        opb_q  <= rd_val_b;
        ldb_q  <= opnd_byte;
        ctrl_q <= decode_op(f_opc);
      end
    end
  end

  assign halted = (phase_q == PH_HALT);
  assign pc     = pc_q;
  assign phase  = phase_q;
endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
  import tcpu_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int ADDR_W = BYTE_W,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              halted,
  input  logic [RIDX_W-1:0] dbg_reg_idx,
  output logic [DATA_W-1:0] dbg_reg_val,
  input  logic [ADDR_W-1:0] dbg_mem_addr,
  output logic [DATA_W-1:0] dbg_mem_val
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;

  logic [ADDR_W-1:0] fa_hi, fa_lo, op_addr, core_waddr, core_pc;
  logic [DATA_W-1:0] fb_hi, fb_lo, op_byte, core_wdata;
  logic [RIDX_W-1:0] ra_idx, rb_idx, rw_idx;
  logic [DATA_W-1:0] ra_val, rb_val, rw_data;
  logic              rw_en, core_we;
  phase_e            core_phase;

  logic              m_we;
  logic [ADDR_W-1:0] m_waddr;
  logic [DATA_W-1:0] m_wdata;

  // Reset asserts at once, deasserts two clock edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // Loader write wins over a core store.
  assign m_we    = ld_we | core_we;
  assign m_waddr = ld_we ? ld_addr : core_waddr;
  assign m_wdata = ld_we ? ld_data : core_wdata;

  tcpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
    .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .ra0(fa_hi), .rd0(fb_hi), .ra1(fa_lo), .rd1(fb_lo),
    .ra2(op_addr), .rd2(op_byte), .ra3(dbg_mem_addr), .rd3(dbg_mem_val)
  );

  tcpu_regfile #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) rf_i (
    .clk(clk), .rst_n(rst_sync_n), .we(rw_en), .widx(rw_idx), .wdata(rw_data),
    .ridx_a(ra_idx), .rval_a(ra_val), .ridx_b(rb_idx), .rval_b(rb_val),
    .ridx_d(dbg_reg_idx), .rval_d(dbg_reg_val)
  );

  tcpu_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) seq_i (
    .clk(clk), .rst_n(rst_sync_n), .start_addr(start_addr),
    .fetch_addr_hi(fa_hi), .fetch_addr_lo(fa_lo), .fetch_hi(fb_hi), .fetch_lo(fb_lo),
    .opnd_addr(op_addr), .opnd_byte(op_byte),
    .rd_idx_a(ra_idx), .rd_idx_b(rb_idx), .rd_val_a(ra_val), .rd_val_b(rb_val),
    .reg_we(rw_en), .reg_widx(rw_idx), .reg_wdata(rw_data),
    .mem_we(core_we), .mem_waddr(core_waddr), .mem_wdata(core_wdata),
    .halted(halted), .pc(core_pc), .phase(core_phase)
  );
endmodule

// File: rtl/tcpu_core_chk.sv
module tcpu_core_chk
  import tcpu_pkg::*;
#(
  parameter int ADDR_W = BYTE_W
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              halted,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] start_addr,
  input phase_e            phase
);
  p_boot_start_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_BOOT) |=> (pc == $past(start_addr)));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_FETCH) |=> (pc == $past(pc) + ADDR_W'(2)));

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halted |=> halted);

  p_halt_pc_frozen_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halted |=> $stable(pc));

  p_fetch_then_decode_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_FETCH) |=> (phase == PH_DECODE));

  p_decode_then_exec_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_DECODE) |=> (phase == PH_EXEC));

  p_exec_leaves_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_EXEC) |=> (phase == PH_FETCH || phase == PH_HALT));
endmodule

bind tcpu_core tcpu_core_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .halted(halted), .pc(core_pc),
  .start_addr(start_addr), .phase(core_phase)
);

// File: tb/tcpu_core_tb.sv
module tcpu_core_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] start_addr;
  logic       ld_we;
  logic [7:0] ld_addr, ld_data;
  logic       halted;
  logic [3:0] dbg_reg_idx;
  logic [7:0] dbg_reg_val, dbg_mem_addr, dbg_mem_val;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [7:0] img   [256];
  logic [7:0] m_mem [256];
  logic [7:0] m_reg [16];

  tcpu_core dut_i (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data), .halted(halted),
    .dbg_reg_idx(dbg_reg_idx), .dbg_reg_val(dbg_reg_val),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_val(dbg_mem_val)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_run(input logic [7:0] start);
    logic [7:0]  pc;
    logic [15:0] ir;
    m_mem = img;
    for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    pc = start;
    for (int step = 1; step <= 500; step++) begin
      ir = {m_mem[pc], m_mem[pc + 8'd1]};
      pc = pc + 8'd2;
      case (ir[15:12])
        4'h1: m_reg[ir[11:8]] = m_mem[ir[7:0]];
        4'h3: m_mem[ir[7:0]] = m_reg[ir[11:8]];
        4'h5: m_reg[ir[11:8]] = m_reg[ir[7:4]] + m_reg[ir[3:0]];
        4'hB: if (m_reg[ir[11:8]] == m_reg[0]) pc = ir[7:0];
        4'hC: return step;
        default: ;
      endcase
    end
    return -1;
  endfunction

  function automatic logic [7:0] rd_reg_now(input int i);
    return 8'h00;
  endfunction

  task automatic put16(input logic [7:0] a, input logic [15:0] w);
    img[a]        = w[15:8];
    img[a + 8'd1] = w[7:0];
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
  endtask

  task automatic get_reg(input int i, output logic [7:0] v);
    dbg_reg_idx = i[3:0];
    #1;
    v = dbg_reg_val;
  endtask

  task automatic get_mem(input int a, output logic [7:0] v);
    dbg_mem_addr = a[7:0];
    #1;
    v = dbg_mem_val;
  endtask

  // Load image under reset, release, wait for halt; returns cycle count.
  task automatic run(input logic [7:0] start, output int cyc);
    logic [7:0] v;
    @(negedge clk);
    rst_n = 1'b0;
    start_addr = start;
    for (int i = 0; i < 256; i++) begin
      ld_we = 1'b1; ld_addr = i[7:0]; ld_data = img[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    chk(halted == 1'b0, "R1 halted in reset", int'(halted), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(halted == 1'b0, "R1 halted after release", int'(halted), 0);
    cyc = 1;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(halted == 1'b1, "R7 halt reached", int'(halted), 1);
    v = 8'h00;
  endtask

  task automatic compare_all(input string req);
    logic [7:0] v;
    int bad_i, bad_a, bad_e;
    bad_i = -1; bad_a = 0; bad_e = 0;
    for (int i = 0; i < 16; i++) begin
      get_reg(i, v);
      if (v !== m_reg[i] && bad_i < 0) begin bad_i = i; bad_a = v; bad_e = m_reg[i]; end
    end
    chk(bad_i < 0, {req, " registers"}, bad_a, bad_e);
    bad_i = -1;
    for (int a = 0; a < 256; a++) begin
      get_mem(a, v);
      if (v !== m_mem[a] && bad_i < 0) begin bad_i = a; bad_a = v; bad_e = m_mem[a]; end
    end
    chk(bad_i < 0, {req, " memory"}, bad_a, bad_e);
  endtask

  logic [3:0] undef_ops [11];

  initial begin
    int c1, c2, st;
    logic [7:0] v, start;
    void'($urandom(32'd5150));
    undef_ops = '{4'h0, 4'h2, 4'h4, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hD, 4'hE, 4'hF};
    rst_n = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    start_addr = '0; dbg_reg_idx = '0; dbg_mem_addr = '0;
    repeat (3) @(negedge clk);

    // R1: registers zero just after reset release (first write is several cycles later)
    clear_img();
    put16(8'h90, 16'h1105);
    put16(8'h92, 16'hC000);
    img[8'h05] = 8'h99;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      ld_we = 1'b1; ld_addr = i[7:0]; ld_data = img[i];
      @(negedge clk);
    end
    ld_we = 1'b0; start_addr = 8'h90;
    rst_n = 1'b1;
    @(negedge clk);
    get_reg(1, v);
    chk(v == 8'h00, "R1 register clear after reset", v, 0);
    get_reg(15, v);
    chk(v == 8'h00, "R1 register 15 clear", v, 0);
    while (!halted) @(negedge clk);
    get_reg(1, v);
    chk(v == 8'h99, "R1 execution from start_addr", v, 8'h99);

    // R3 R4 R5: load/load/add/store/halt example
    clear_img();
    put16(8'hA0, 16'h156C); put16(8'hA2, 16'h166D); put16(8'hA4, 16'h5056);
    put16(8'hA6, 16'h306E); put16(8'hA8, 16'hC000);
    img[8'h6C] = 8'h2B; img[8'h6D] = 8'hFF;
    st = model_run(8'hA0);
    run(8'hA0, c1);
    get_reg(5, v); chk(v == 8'h2B, "R3 load r5", v, 8'h2B);
    get_reg(6, v); chk(v == 8'hFF, "R3 load r6", v, 8'hFF);
    get_reg(0, v); chk(v == 8'h2A, "R5 add wraps 2B+FF", v, 8'h2A);
    get_mem(8'h6E, v); chk(v == 8'h2A, "R4 store r0", v, 8'h2A);
    compare_all("R3 R4 R5 example");

    // R5: signed overflow wrap 7F+01
    clear_img();
    put16(8'h40, 16'h1110); put16(8'h42, 16'h1211); put16(8'h44, 16'h5312);
    put16(8'h46, 16'hC000);
    img[8'h10] = 8'h7F; img[8'h11] = 8'h01;
    st = model_run(8'h40);
    run(8'h40, c1);
    get_reg(3, v); chk(v == 8'h80, "R5 overflow 7F+01", v, 8'h80);

    // R6: taken (equal), not taken, unconditional via register 0
    clear_img();
    put16(8'hC0, 16'h1120);          // r1 = 5
    put16(8'hC2, 16'hB1C8);          // r1 != r0 -> fall through
    put16(8'hC4, 16'h3121);          // store r1 -> 21
    put16(8'hC6, 16'hB0CC);          // unconditional -> CC
    put16(8'hC8, 16'h3122);          // skipped
    put16(8'hCA, 16'hC000);
    put16(8'hCC, 16'hB2D0);          // r2 == r0 (both 0) -> D0
    put16(8'hCE, 16'h3123);          // skipped
    put16(8'hD0, 16'hC000);
    img[8'h20] = 8'h05;
    st = model_run(8'hC0);
    run(8'hC0, c1);
    get_mem(8'h21, v); chk(v == 8'h05, "R6 not-taken continues", v, 5);
    get_mem(8'h22, v); chk(v == 8'h00, "R6 unconditional skips", v, 0);
    get_mem(8'h23, v); chk(v == 8'h00, "R6 equal taken skips", v, 0);
    compare_all("R6 jumps");

    // R2: start at FF, instruction straddles FF/00
    clear_img();
    img[8'hFF] = 8'h11; img[8'h00] = 8'h05;
    put16(8'h01, 16'hC000);
    img[8'h05] = 8'h77;
    st = model_run(8'hFF);
    run(8'hFF, c1);
    get_reg(1, v); chk(v == 8'h77, "R2 straddle fetch and wrap", v, 8'h77);

    // R2: instruction at FE, next fetch wraps to 00
    clear_img();
    put16(8'hFE, 16'h1208);
    put16(8'h00, 16'h3209); put16(8'h02, 16'hC000);
    img[8'h08] = 8'h3C;
    st = model_run(8'hFE);
    run(8'hFE, c1);
    get_mem(8'h09, v); chk(v == 8'h3C, "R2 pc wrap FE to 00", v, 8'h3C);

    // R8: undefined opcodes change nothing
    clear_img();
    for (int k = 0; k < 11; k++) put16(8'h60 + 8'(2 * k), {undef_ops[k], 4'h1, 8'h30});
    put16(8'h76, 16'h3731); put16(8'h78, 16'hC000);
    img[8'h30] = 8'hAB; img[8'h31] = 8'h5A;
    st = model_run(8'h60);
    run(8'h60, c1);
    get_reg(1, v); chk(v == 8'h00, "R8 undefined leaves r1", v, 0);
    get_mem(8'h31, v); chk(v == 8'h00, "R8 continues to next instruction", v, 0);
    compare_all("R8 undefined");

    // R7: instructions after halt never run; state frozen
    clear_img();
    put16(8'h50, 16'hC000); put16(8'h52, 16'h3010);
    img[8'h10] = 8'h55;
    st = model_run(8'h50);
    run(8'h50, c1);
    repeat (20) @(negedge clk);
    chk(halted == 1'b1, "R7 halted sticky", int'(halted), 1);
    get_mem(8'h10, v); chk(v == 8'h55, "R7 no execution past halt", v, 8'h55);

    // R9: three extra instructions delay halt by 9 cycles
    clear_img();
    put16(8'h90, 16'hC000);
    run(8'h90, c1);
    clear_img();
    put16(8'h90, 16'h2000); put16(8'h92, 16'h4000); put16(8'h94, 16'hF123);
    put16(8'h96, 16'hC000);
    run(8'h90, c2);
    chk(c2 - c1 == 9, "R9 three cycles per instruction", c2 - c1, 9);

    // Random programs: R3 R4 R5 R6 R8 against the bench model
    for (int t = 0; t < 20; t++) begin
      int n, kind, tgt;
      logic [3:0] r, s, u;
      clear_img();
      for (int a = 0; a < 64; a++) img[a] = 8'($urandom);
      start = 8'h80 + 8'(2 * ($urandom % 8));
      n = 4 + int'($urandom % 10);
      for (int i = 0; i < n - 1; i++) begin
        kind = int'($urandom % 6);
        r = 4'($urandom); s = 4'($urandom); u = 4'($urandom);
        case (kind)
          0: put16(start + 8'(2 * i), {4'h1, r, 8'($urandom % 64)});
          1: put16(start + 8'(2 * i), {4'h3, r, 8'($urandom % 64)});
          3: begin
            tgt = i + 1 + int'($urandom % (n - 1 - i));
            put16(start + 8'(2 * i), {4'hB, r, start + 8'(2 * tgt)});
          end
          4: put16(start + 8'(2 * i), {undef_ops[$urandom % 11], r, s, u});
          default: put16(start + 8'(2 * i), {4'h5, r, s, u});
        endcase
      end
      put16(start + 8'(2 * (n - 1)), 16'hC000);
      st = model_run(start);
      run(start, c1);
      compare_all("R3 R4 R5 R6 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule